// File: doc/BRIEF.md
# Serial Command Port for a Twelve-Output Switch Controller

This block is the host-facing serial port of a load-switch controller with twelve outputs. A host drives a four-wire serial link: a clock, a data input, an active-low select and a data output. The host sends 16-bit command words. Each word carries a watchdog bit, a 3-bit register address and twelve data bits. Address zero holds the on/off state of the twelve outputs, and the other seven addresses hold generic configuration words. A received word takes effect only when the select line is released, and only if a whole number of 16-bit words was clocked in. Longer multiples of 16 are accepted, and the last 16 bits received are the ones that take effect.

While the select line is low, the block returns a status word. It is captured at the moment the select line falls. It holds one fault flag per output and three of six direct-input levels, and the watchdog bit stored by the previous valid command selects which three. That stored watchdog bit is returned as well. Once the status word has been sent, the bits received earlier come out on the data output, so several devices can share one select line in a chain. The serial pins are brought into the system clock domain through two-flop synchronizers. The system clock must be at least four times faster than the serial clock.

Top module: `spi_switch_ctrl`

## Requirements
- R1: A frame moves most significant bit first. The last 16 bits received form the command: bit 15 is the watchdog bit, bits 14..12 are the address and bits 11..0 are the data.
- R2: A valid command with address 0 sets `out_en_o[i]` to data bit i. A 1 turns the output on and a 0 turns it off.
- R3: A valid command with address a (1..7) loads its data into `cfg_o[(a-1)*12 +: 12]` and leaves the other registers unchanged.
- R4: The reply is sent MSB first, and its bits 11..0 equal `fault_i` as sampled when the select line falls.
- R5: Reply bits 14..12 equal `din_i[2:0]` when the stored watchdog bit is 0 and `din_i[5:3]` when it is 1. Reply bit 15 equals the stored watchdog bit. Each valid command updates the stored bit, which `wd_o` shows.
- R6: Registers change only after the select line rises. They stay constant while a frame is in progress.
- R7: If the select line rises after a bit count that is zero or not a multiple of 16, no register changes, including the watchdog bit.
- R8: Once 16 reply bits have been sent, the data output forwards the received bits in the order they arrived.
- R9: While the select line is high, `so_oe_o` is 0 and serial-clock and data activity has no effect. `so_oe_o` is 1 while the select line is low.
- R10: Reset clears every output enable, every configuration register and the stored watchdog bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial command data |
| csb_i | input | 1 | Active-low frame select |
| so_o | output | 1 | Serial reply data |
| so_oe_o | output | 1 | Reply driver enable (pad tri-state control) |
| fault_i | input | 12 | Per-output fault flags |
| din_i | input | 6 | Direct-input levels |
| out_en_o | output | 12 | Output on/off state |
| cfg_o | output | 84 | Seven 12-bit configuration words |
| wd_o | output | 1 | Stored watchdog bit |

## Verification
The bench covers short and unaligned frames (10 and 20 bits) and an empty frame. A design that committed on every release of the select line would corrupt a register or flip the watchdog bit in these cases. A 32-bit frame checks the forwarding path and that the trailing word is the one that takes effect. An off-by-one in the reply shift would show up here as a duplicated or lost bit. Frames that toggle the watchdog bit catch a design that selects the input group from the current word rather than from the stored one. Serial-clock activity with the select line high catches a design that does not gate the clock on the select line: it would leave stale bits in the shifter or drive the data output.

// File: rtl/spi_sw_pkg.sv
package spi_sw_pkg;
  localparam int SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/spi_sw_sync.sv
module spi_sw_sync
  import spi_sw_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES_DEF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  logic  si_i,
  input  logic  csb_i,
  output edge_t sclk_edge_o,
  output edge_t csb_edge_o,
  output logic  si_o,
  output logic  csb_low_o
);
  localparam int LAST = STAGES - 1;
  localparam logic [2:0] IDLE = 3'b100;  // {csb, si, sclk}

  logic [STAGES-1:0][2:0] sync_q;
  logic sclk_q, csb_q;
  logic sclk_s, si_s, csb_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{IDLE}};
    end else begin
      sync_q[0] <= {csb_i, si_i, sclk_i};
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign {csb_s, si_s, sclk_s} = sync_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csb_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csb_q  <= csb_s;
    end
  end

  // serial clock edges count only inside a frame
  assign sclk_edge_o.rise = sclk_s & ~sclk_q & ~csb_s;
  assign sclk_edge_o.fall = ~sclk_s & sclk_q & ~csb_s;
  assign csb_edge_o.rise  = csb_s & ~csb_q;
  assign csb_edge_o.fall  = ~csb_s & csb_q;
  assign si_o             = si_s;
  assign csb_low_o        = ~csb_s;
endmodule

// File: rtl/spi_sw_shift.sv
module spi_sw_shift
  import spi_sw_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  edge_t              sclk_edge_i,
  input  edge_t              csb_edge_i,
  input  logic               csb_low_i,
  input  logic               si_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               so_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               frame_ok_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] tx_sr_q, rx_sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               seen_q, si_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
      cnt_q     <= '0;
      seen_q    <= 1'b0;
      si_hold_q <= 1'b0;
    end else if (csb_edge_i.fall) begin
      tx_sr_q <= status_i;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (sclk_edge_i.fall) begin
        rx_sr_q   <= {rx_sr_q[FRAME_W-2:0], si_i};
        si_hold_q <= si_i;
        cnt_q     <= cnt_q + 1'b1;
        seen_q    <= 1'b1;
      end
      // first rising edge presents the MSB already loaded; later ones advance
      if (sclk_edge_i.rise && seen_q)
        tx_sr_q <= {tx_sr_q[FRAME_W-2:0], si_hold_q};
    end
  end

  assign so_o       = tx_sr_q[FRAME_W-1];
  assign rx_word_o  = rx_sr_q;
  assign frame_ok_o = seen_q && (cnt_q == '0);

  a_r4_status_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_edge_i.fall |=> tx_sr_q == $past(status_i));

  a_r9_idle_no_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csb_low_i |-> !(sclk_edge_i.rise || sclk_edge_i.fall));

  a_r8_one_bit_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_edge_i.rise && seen_q && !csb_edge_i.fall)
      |=> tx_sr_q[FRAME_W-1] == $past(tx_sr_q[FRAME_W-2]));
endmodule

// File: rtl/spi_sw_regs.sv
module spi_sw_regs #(
  parameter int N_OUT  = 12,
  parameter int ADDR_W = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W+N_OUT:0]            word_i,
  output logic [N_OUT-1:0]                 out_en_o,
  output logic [(2**ADDR_W-1)*N_OUT-1:0]   cfg_o,
  output logic                             wd_o
);
  localparam int N_CFG   = 2**ADDR_W - 1;
  localparam int FRAME_W = ADDR_W + N_OUT + 1;

  logic [ADDR_W-1:0] addr;
  logic [N_OUT-1:0]  data;
  logic [N_OUT-1:0]  out_en_q;
  logic              wd_q;

  assign addr = word_i[N_OUT +: ADDR_W];
  assign data = word_i[N_OUT-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_en_q <= '0;
      wd_q     <= 1'b0;
    end else if (wr_en_i) begin
      wd_q <= word_i[FRAME_W-1];
      if (addr == '0) out_en_q <= data;
    end
  end

  for (genvar a = 1; a <= N_CFG; a++) begin : g_cfg
    logic [N_OUT-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (wr_en_i && addr == ADDR_W'(a))     q <= data;
    end
    assign cfg_o[(a-1)*N_OUT +: N_OUT] = q;
  end

  assign out_en_o = out_en_q;
  assign wd_o     = wd_q;

  a_r6_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(out_en_o) && $stable(cfg_o) && $stable(wd_o));

  a_r2_onoff_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == '0) |=> out_en_o == $past(data));

  a_r3_cfg_untouched_by_onoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == '0) |=> $stable(cfg_o));
endmodule

// File: rtl/spi_switch_ctrl.sv
module spi_switch_ctrl
  import spi_sw_pkg::*;
#(
  parameter int N_OUT       = 12,
  parameter int ADDR_W      = 3,
  parameter int N_DIN       = 6,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sclk_i,
  input  logic                            si_i,
  input  logic                            csb_i,
  output logic                            so_o,
  output logic                            so_oe_o,
  input  logic [N_OUT-1:0]                fault_i,
  input  logic [N_DIN-1:0]                din_i,
  output logic [N_OUT-1:0]                out_en_o,
  output logic [(2**ADDR_W-1)*N_OUT-1:0]  cfg_o,
  output logic                            wd_o
);
  localparam int FRAME_W = ADDR_W + N_OUT + 1;
  localparam int DIN_GRP = N_DIN / 2;

  edge_t              sclk_edge, csb_edge;
  logic               si_s, csb_low, sr_msb, frame_ok, wr_en;
  logic [FRAME_W-1:0] rx_word, status;
  logic [DIN_GRP-1:0] din_sel;

  spi_sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .si_i        (si_i),
    .csb_i       (csb_i),
    .sclk_edge_o (sclk_edge),
    .csb_edge_o  (csb_edge),
    .si_o        (si_s),
    .csb_low_o   (csb_low)
  );

  // input group chosen by the watchdog bit stored from the last valid command
  assign din_sel = wd_o ? din_i[N_DIN-1 -: DIN_GRP] : din_i[DIN_GRP-1:0];
  assign status  = {wd_o, din_sel, fault_i};

  spi_sw_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_edge_i (sclk_edge),
    .csb_edge_i  (csb_edge),
    .csb_low_i   (csb_low),
    .si_i        (si_s),
    .status_i    (status),
    .so_o        (sr_msb),
    .rx_word_o   (rx_word),
    .frame_ok_o  (frame_ok)
  );

  assign wr_en = csb_edge.rise & frame_ok;

  spi_sw_regs #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .word_i   (rx_word),
    .out_en_o (out_en_o),
    .cfg_o    (cfg_o),
    .wd_o     (wd_o)
  );

  assign so_oe_o = csb_low;
  assign so_o    = csb_low & sr_msb;

  a_r5_wd_changes_on_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csb_edge.rise |=> $stable(wd_o));
endmodule

// File: tb/tb_spi_switch_ctrl.sv
module tb_spi_switch_ctrl;
  localparam int CLK_P  = 10;
  localparam int N_OUT  = 12;
  localparam int ADDR_W = 3;
  localparam int N_DIN  = 6;
  localparam int N_CFG  = 7;
  localparam int FW     = 16;
  localparam int HALF   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, si = 1'b0, csb = 1'b1;
  logic so, so_oe, wd;
  logic [N_OUT-1:0] fault = '0, out_en;
  logic [N_DIN-1:0] din = '0;
  logic [N_CFG*N_OUT-1:0] cfg;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [N_OUT-1:0] out_m;
  logic [N_OUT-1:0] cfg_m [N_CFG];
  logic wd_m;

  spi_switch_ctrl #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .N_DIN(N_DIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .si_i(si), .csb_i(csb),
    .so_o(so), .so_oe_o(so_oe), .fault_i(fault), .din_i(din),
    .out_en_o(out_en), .cfg_o(cfg), .wd_o(wd)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [FW-1:0] exp_reply(input logic w, input logic [N_DIN-1:0] d,
                                              input logic [N_OUT-1:0] f);
    return {w, (w ? d[5:3] : d[2:0]), f};
  endfunction

  function automatic logic [N_CFG*N_OUT-1:0] cfg_pack();
    logic [N_CFG*N_OUT-1:0] v;
    for (int a = 0; a < N_CFG; a++) v[a*N_OUT +: N_OUT] = cfg_m[a];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [63:0] bits, input int nbits);
    logic [63:0] so_cap, exp_so;
    logic [FW-1:0] rep, w;
    logic [N_OUT-1:0] out0;
    logic [N_CFG*N_OUT-1:0] cfg0;
    bit oe_ok, stable_ok, good;
    string lbl;
    so_cap = '0; exp_so = '0; oe_ok = 1; stable_ok = 1;
    out0 = out_en; cfg0 = cfg;
    rep  = exp_reply(wd_m, din, fault);
    good = (nbits > 0) && (nbits % FW == 0);
    csb = 1'b0;
    repeat (6) @(negedge clk);
    if (!so_oe) oe_ok = 0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      si   = bits[nbits-1-i];
      repeat (HALF) @(negedge clk);
      so_cap[nbits-1-i] = so;
      if (!so_oe) oe_ok = 0;
      if (out_en !== out0 || cfg !== cfg0) stable_ok = 0;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    for (int i = 0; i < nbits; i++)
      exp_so[nbits-1-i] = (i < FW) ? rep[FW-1-i] : bits[nbits-1-(i-FW)];
    repeat (HALF) @(negedge clk);
    csb = 1'b1;
    repeat (6) @(negedge clk);
    lbl = (nbits > FW) ? "R8 reply+forward" : (good ? "R4 R5 reply" : "R7 partial reply");
    check(lbl, 128'(so_cap), 128'(exp_so));
    check("R9 oe during frame", 128'(oe_ok), 128'(1));
    check("R9 oe after release", 128'(so_oe), 128'(0));
    check("R6 stable mid-frame", 128'(stable_ok), 128'(1));
    if (good) begin
      w = bits[FW-1:0];
      wd_m = w[15];
      if (w[14:12] == 3'd0) out_m = w[11:0];
      else cfg_m[w[14:12]-1] = w[11:0];
    end
    lbl = good ? "R1 R2 outputs" : "R7 outputs";
    check(lbl, 128'(out_en), 128'(out_m));
    lbl = good ? "R3 cfg" : "R7 cfg";
    check(lbl, 128'(cfg), 128'(cfg_pack()));
    lbl = good ? "R5 wd" : "R7 wd";
    check(lbl, 128'(wd), 128'(wd_m));
  endtask

  task automatic idle_noise();
    bit oe_ok;
    oe_ok = 1;
    for (int i = 0; i < 24; i++) begin
      sclk = ~sclk;
      si   = 1'($urandom);
      repeat (3) @(negedge clk);
      if (so_oe) oe_ok = 0;
    end
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 oe idle", 128'(oe_ok), 128'(1));
    check("R9 outputs idle", 128'(out_en), 128'(out_m));
    check("R9 cfg idle", 128'(cfg), 128'(cfg_pack()));
    check("R9 wd idle", 128'(wd), 128'(wd_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    out_m = '0; wd_m = 1'b0;
    for (int a = 0; a < N_CFG; a++) cfg_m[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 outputs", 128'(out_en), 128'(0));
    check("R10 cfg", 128'(cfg), 128'(0));
    check("R10 wd", 128'(wd), 128'(0));
    check("R9 oe reset", 128'(so_oe), 128'(0));

    // R5: set watchdog, then the reply must show the upper input group
    fault = 12'hA5C; din = 6'b101_010;
    run_frame(64'h8ABC, 16);
    fault = 12'h3C3; din = 6'b011_100;
    run_frame(64'h0F0F, 16);
    run_frame(64'h1123, 16);

    // R1..R5 random frames
    for (int k = 0; k < 40; k++) begin
      fault = N_OUT'($urandom);
      din   = N_DIN'($urandom);
      run_frame(64'(16'($urandom)), 16);
    end

    // R7 unaligned and empty frames
    fault = 12'hFFF; din = 6'b111_000;
    run_frame(64'h2AB, 10);
    run_frame(64'hF_7654, 20);
    run_frame(64'h0, 0);

    // R8 daisy chain: 32 bits, last 16 take effect
    fault = 12'h081;
    run_frame(64'hE111_6ABC, 32);
    run_frame(64'h0000_0FFF, 32);

    // R9 activity while released
    idle_noise();
    run_frame(64'h7555, 16);
    idle_noise();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule